// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast input clock by a ratio whose long-term mean is INT + FRAC/MOD. Each output cycle lasts a whole number of input clocks. That count is the integer part plus a small signed offset, and a three-stage cascaded-accumulator noise shaper chooses the offset so that the fractional remainder averages out exactly over time. The modulus is any value from 2 up to the full field width. It does not need to be a power of two.

Software loads a new ratio by holding `cfg_load_i` for one clock while the three values are on their inputs. The block validates the load at once. A legal set waits as a pending configuration and replaces the active one at the next output-cycle boundary. An illegal set raises `cfg_err_o` and is discarded. The block also contains a small integer divider that runs on its own reference clock and produces a reference pulse every R clocks.

Top module: `fracn_fbdiv`

## Requirements
- R1: After reset, `div_val_o` reads 32, `cfg_err_o` is 0, and output pulses come every 32 input clocks (integer 32, fraction 0).
- R2: `div_pulse_o` is high for exactly one input clock. The number of clocks from one pulse to the next equals `div_val_o` as sampled during the second of those two pulses.
- R3: A load with an integer part below 31 sets `cfg_err_o` on the following clock and leaves the output period unchanged.
- R4: A load with a modulus below 2 sets `cfg_err_o` and is not applied.
- R5: A load with FRAC greater than or equal to MOD sets `cfg_err_o` and is not applied.
- R6: A legal load clears `cfg_err_o` on the following clock. It does not shorten or lengthen the output cycle already under way. It takes effect from the next cycle on.
- R7: With FRAC = 0, every output cycle lasts exactly INT clocks.
- R8: Consider any 6·MOD consecutive output cycles, starting from the third cycle after a configuration is applied. Together they last exactly 6·(INT·MOD + FRAC) input clocks.
- R9: Every output cycle lasts between INT−3 and INT+4 clocks.
- R10: The modulator state restarts from zero when a configuration is applied, so the first output cycle under a new configuration lasts exactly INT clocks.
- R11: For a reference ratio R from 1 to 15, `ref_pulse_o` is high for one reference clock in every R reference clocks. At R = 1 it is high continuously.
- R12: With R = 0, `ref_err_o` is 1 and `ref_pulse_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_i | input | 1 | Active-high synchronous reset, shared by both clocks |
| cfg_load_i | input | 1 | One-clock strobe that captures the three ratio values |
| int_i | input | 9 | Integer part of the ratio, legal range 31..511 |
| frac_i | input | 12 | Fraction numerator, legal range 0..MOD−1 |
| mod_i | input | 12 | Fraction modulus, legal range 2..4095 |
| ref_clk_i | input | 1 | Reference clock for the reference divider |
| ref_div_i | input | 4 | Reference ratio R, 1..15 (0 is illegal) |
| div_pulse_o | output | 1 | One-clock pulse marking the end of each output cycle |
| div_val_o | output | 10 | Length in clocks of the output cycle now running |
| cfg_err_o | output | 1 | Set by a rejected load, cleared by an accepted one |
| ref_pulse_o | output | 1 | Divided reference pulse |
| ref_err_o | output | 1 | High while R is 0 |

## Verification
The exact-average property is the hardest to observe from the ports. Its carry terms only cancel once every accumulator stage has returned to zero, and that happens only after a multiple of 6·MOD modulator steps. The stimulus sweeps several small moduli, including primes and the smallest legal one. For each, it discards the first two cycles after the configuration is applied, then counts clocks over a full 6·MOD window and compares the total with the arithmetic value. A second situation that needs care is a load that arrives in the middle of an output cycle. For that case the stimulus times the strobe between two pulses and measures the interval that contains the strobe.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   // number of cascaded accumulator stages in the noise shaper
   localparam int SHAPER_STAGES = 3;
   // signed offset range produced by the three-stage shaper
   localparam int OFS_LO = -3;
   localparam int OFS_HI = 4;
   typedef logic signed [3:0] ofs_t;
endpackage

// File: rtl/fracn_accum.sv
// One modulo-MOD accumulator stage: adds an input to the state and
// wraps at the modulus, flagging the wrap as a carry.
module fracn_accum #(
   parameter int W = 12
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] add_i,
   input  logic [W-1:0] mod_i,
   output logic [W-1:0] acc_o,
   output logic         carry_o
);
   logic [W:0] sum;

   always_comb begin
      sum     = {1'b0, acc_i} + {1'b0, add_i};
      carry_o = (sum >= {1'b0, mod_i});
      acc_o   = carry_o ? W'(sum - {1'b0, mod_i}) : sum[W-1:0];
   end
endmodule

// File: rtl/fracn_shaper.sv
// Cascade of accumulator stages with carry recombination giving a
// third-order noise-shaped offset per output cycle.
module fracn_shaper
   import fracn_pkg::*;
#(
   parameter int W_MOD = 12
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             step_i,
   input  logic             restart_i,
   input  logic [W_MOD-1:0] frac_i,
   input  logic [W_MOD-1:0] mod_i,
   output ofs_t             ofs_o
);
   localparam int NS = SHAPER_STAGES;

   logic [NS-1:0][W_MOD-1:0] acc_q, acc_in, acc_nx, add_v;
   logic [NS-1:0]            cy;
   logic                     c2d_q, c3d_q, c3dd_q;
   logic                     c2d, c3d, c3dd;

   for (genvar k = 0; k < NS; k++) begin : g_stage
      assign acc_in[k] = restart_i ? '0 : acc_q[k];
      if (k == 0) begin : g_first
         assign add_v[k] = frac_i;
      end else begin : g_chain
         assign add_v[k] = acc_nx[k-1];
      end
      fracn_accum #(.W(W_MOD)) acc_u (
         .acc_i   (acc_in[k]),
         .add_i   (add_v[k]),
         .mod_i   (mod_i),
         .acc_o   (acc_nx[k]),
         .carry_o (cy[k])
      );
   end

   assign c2d  = restart_i ? 1'b0 : c2d_q;
   assign c3d  = restart_i ? 1'b0 : c3d_q;
   assign c3dd = restart_i ? 1'b0 : c3dd_q;

   always_comb begin
      ofs_o = $signed({3'b000, cy[0]})
            + $signed({3'b000, cy[1]}) - $signed({3'b000, c2d})
            + $signed({3'b000, cy[2]}) - $signed({2'b00, c3d, 1'b0})
            + $signed({3'b000, c3dd});
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q  <= '0;
         c2d_q  <= 1'b0;
         c3d_q  <= 1'b0;
         c3dd_q <= 1'b0;
      end else if (step_i) begin
         acc_q  <= acc_nx;
         c2d_q  <= cy[1];
         c3d_q  <= cy[2];
         c3dd_q <= c3d;
      end
   end

   // R9: the recombined offset never leaves the shaper's range
   a_r9_ofs_bounds: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i |-> (ofs_o >= 4'(OFS_LO)) && (ofs_o <= 4'(OFS_HI)));
endmodule

// File: rtl/fracn_cfg.sv
// Validates ratio loads, holds a pending set, and swaps it in at a boundary.
module fracn_cfg #(
   parameter int W_INT   = 9,
   parameter int W_MOD   = 12,
   parameter int INT_MIN = 31,
   parameter int MOD_MIN = 2,
   parameter int RST_INT = 32
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [W_INT-1:0] int_i,
   input  logic [W_MOD-1:0] frac_i,
   input  logic [W_MOD-1:0] mod_i,
   input  logic             apply_i,
   output logic [W_INT-1:0] eff_int_o,
   output logic [W_MOD-1:0] eff_frac_o,
   output logic [W_MOD-1:0] eff_mod_o,
   output logic [W_INT-1:0] act_int_o,
   output logic             restart_o,
   output logic             err_o
);
   logic [W_INT-1:0] act_int, pend_int;
   logic [W_MOD-1:0] act_frac, pend_frac, act_mod, pend_mod;
   logic             pend_v;
   logic             int_ok, mod_ok, frac_ok, legal;

   assign int_ok  = (int_i >= W_INT'(INT_MIN));
   assign mod_ok  = (mod_i >= W_MOD'(MOD_MIN));
   assign frac_ok = (frac_i < mod_i);
   assign legal   = int_ok && mod_ok && frac_ok;

   assign eff_int_o  = pend_v ? pend_int  : act_int;
   assign eff_frac_o = pend_v ? pend_frac : act_frac;
   assign eff_mod_o  = pend_v ? pend_mod  : act_mod;
   assign restart_o  = pend_v;
   assign act_int_o  = act_int;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         act_int   <= W_INT'(RST_INT);
         act_frac  <= '0;
         act_mod   <= W_MOD'(MOD_MIN);
         pend_int  <= '0;
         pend_frac <= '0;
         pend_mod  <= '0;
         pend_v    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         if (apply_i) begin
            act_int  <= eff_int_o;
            act_frac <= eff_frac_o;
            act_mod  <= eff_mod_o;
            pend_v   <= 1'b0;
         end
         if (load_i) begin
            if (legal) begin
               pend_int  <= int_i;
               pend_frac <= frac_i;
               pend_mod  <= mod_i;
               pend_v    <= 1'b1;
               err_o     <= 1'b0;
            end else begin
               err_o <= 1'b1;
            end
         end
      end
   end

   a_r3_int_reject: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i && (int_i < W_INT'(INT_MIN)) |=> err_o);
   a_r4_mod_reject: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i && (mod_i < W_MOD'(MOD_MIN)) |=> err_o);
   a_r5_frac_reject: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i && (frac_i >= mod_i) |=> err_o && $stable(act_int));
   a_r6_err_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i && legal |=> !err_o);
endmodule

// File: rtl/fracn_refdiv.sv
// Integer reference divider with its own clock; ratio zero is illegal.
module fracn_refdiv #(
   parameter int W_R = 4
) (
   input  logic           ref_clk_i,
   input  logic           rst_i,
   input  logic [W_R-1:0] r_i,
   output logic           pulse_o,
   output logic           err_o
);
   logic [W_R-1:0] cnt;

   assign err_o   = (r_i == '0);
   assign pulse_o = !err_o && (cnt == '0);

   always_ff @(posedge ref_clk_i) begin
      if (rst_i) begin
         cnt <= '0;
      end else if (err_o) begin
         cnt <= '0;
      end else if (cnt == '0) begin
         cnt <= r_i - 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   a_r11_ref_gap: assert property (@(posedge ref_clk_i) disable iff (rst_i)
      pulse_o && (r_i > W_R'(1)) && $stable(r_i) |=> !pulse_o);
   a_r12_ref_quiet: assert property (@(posedge ref_clk_i) disable iff (rst_i)
      (r_i == '0) |=> (r_i != '0) || !pulse_o);
endmodule

// File: rtl/fracn_fbdiv.sv
// Fractional-N feedback divider top: cycle counter plus shaper and config.
module fracn_fbdiv
   import fracn_pkg::*;
#(
   parameter int W_INT   = 9,
   parameter int W_MOD   = 12,
   parameter int W_R     = 4,
   parameter int INT_MIN = 31,
   parameter int MOD_MIN = 2,
   parameter int RST_INT = 32
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               cfg_load_i,
   input  logic [W_INT-1:0]   int_i,
   input  logic [W_MOD-1:0]   frac_i,
   input  logic [W_MOD-1:0]   mod_i,
   input  logic               ref_clk_i,
   input  logic [W_R-1:0]     ref_div_i,
   output logic               div_pulse_o,
   output logic [W_INT:0]     div_val_o,
   output logic               cfg_err_o,
   output logic               ref_pulse_o,
   output logic               ref_err_o
);
   localparam int W_N = W_INT + 1;

   if (INT_MIN + OFS_LO < 2) begin : g_bad_min
      $error("INT_MIN too small for the shaper's negative offset");
   end
   if (RST_INT < INT_MIN || RST_INT >= (1 << W_INT)) begin : g_bad_rst
      $error("RST_INT outside the legal integer range");
   end
   if (MOD_MIN < 2 || W_MOD < 2) begin : g_bad_mod
      $error("modulus configuration too small");
   end

   logic [W_INT-1:0] eff_int, act_int;
   logic [W_MOD-1:0] eff_frac, eff_mod;
   logic             restart;
   ofs_t             ofs;
   logic [W_N-1:0]   cnt, next_n;
   logic signed [W_INT+1:0] sum_s;

   fracn_cfg #(
      .W_INT(W_INT), .W_MOD(W_MOD), .INT_MIN(INT_MIN),
      .MOD_MIN(MOD_MIN), .RST_INT(RST_INT)
   ) cfg_u (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (cfg_load_i),
      .int_i      (int_i),
      .frac_i     (frac_i),
      .mod_i      (mod_i),
      .apply_i    (div_pulse_o),
      .eff_int_o  (eff_int),
      .eff_frac_o (eff_frac),
      .eff_mod_o  (eff_mod),
      .act_int_o  (act_int),
      .restart_o  (restart),
      .err_o      (cfg_err_o)
   );

   fracn_shaper #(.W_MOD(W_MOD)) shaper_u (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .step_i    (div_pulse_o),
      .restart_i (restart),
      .frac_i    (eff_frac),
      .mod_i     (eff_mod),
      .ofs_o     (ofs)
   );

   assign sum_s  = $signed({2'b00, eff_int}) + {{(W_INT-2){ofs[3]}}, ofs};
   assign next_n = sum_s[W_N-1:0];
   assign div_pulse_o = (cnt == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt       <= W_N'(RST_INT - 1);
         div_val_o <= W_N'(RST_INT);
      end else if (div_pulse_o) begin
         cnt       <= next_n - 1'b1;
         div_val_o <= next_n;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   fracn_refdiv #(.W_R(W_R)) ref_u (
      .ref_clk_i (ref_clk_i),
      .rst_i     (rst_i),
      .r_i       (ref_div_i),
      .pulse_o   (ref_pulse_o),
      .err_o     (ref_err_o)
   );

   a_r2_pulse_width: assert property (@(posedge clk_i) disable iff (rst_i)
      div_pulse_o |=> !div_pulse_o);
   a_r6_len_held: assert property (@(posedge clk_i) disable iff (rst_i)
      !div_pulse_o |=> $stable(div_val_o));
   a_r9_len_window: assert property (@(posedge clk_i) disable iff (rst_i)
      (int'(div_val_o) >= int'(act_int) + OFS_LO) &&
      (int'(div_val_o) <= int'(act_int) + OFS_HI));
endmodule

// File: tb/fracn_fbdiv_tb_top.sv
module fracn_fbdiv_tb_top;
   logic       clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst = 1'b1;
   logic       load = 1'b0;
   logic [8:0] ni = '0;
   logic [11:0] fr = '0;
   logic [11:0] md = '0;
   logic [3:0] rdiv = 4'd5;
   logic       pulse, cerr, rpulse, rerr;
   logic [9:0] dval;

   int cyc = 0;
   int rcyc = 0;
   int checks = 0;
   int errors = 0;
   int last_p = 0;
   bit done = 0;

   always #10 clk = ~clk;
   always #7 ref_clk = ~ref_clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge ref_clk) rcyc <= rcyc + 1;

   fracn_fbdiv dut_i (
      .clk_i(clk), .rst_i(rst), .cfg_load_i(load), .int_i(ni), .frac_i(fr),
      .mod_i(md), .ref_clk_i(ref_clk), .ref_div_i(rdiv),
      .div_pulse_o(pulse), .div_val_o(dval), .cfg_err_o(cerr),
      .ref_pulse_o(rpulse), .ref_err_o(rerr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_pulse(output int ival, output int dv);
      @(negedge clk);
      while (!pulse) @(negedge clk);
      ival   = cyc - last_p;
      last_p = cyc;
      dv     = int'(dval);
   endtask

   task automatic do_load(input int i, input int f, input int m);
      @(negedge clk);
      ni = 9'(i); fr = 12'(f); md = 12'(m); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic ref_interval(output int iv);
      int s;
      @(negedge ref_clk);
      while (!rpulse) @(negedge ref_clk);
      s = rcyc;
      @(negedge ref_clk);
      while (!rpulse) @(negedge ref_clk);
      iv = rcyc - s;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int iv, dv, bad, tot, n6;
      int cfgs [5][3] = '{'{31, 1, 2}, '{31, 3, 5}, '{64, 6, 7},
                          '{200, 10, 13}, '{511, 2, 3}};
      repeat (4) @(negedge clk);
      rst = 1'b0;
      last_p = cyc;
      @(negedge clk);
      // R1 reset state
      chk(dval == 10'd32, "R1 reset length", int'(dval), 32);
      chk(cerr == 1'b0, "R1 reset error flag", int'(cerr), 0);
      next_pulse(iv, dv);
      next_pulse(iv, dv);
      chk(iv == 32, "R1 reset period", iv, 32);
      @(negedge clk);
      chk(pulse == 1'b0, "R2 pulse one clock wide", int'(pulse), 0);

      // R7 integer mode
      do_load(40, 0, 7);
      next_pulse(iv, dv);
      bad = 0;
      for (int k = 0; k < 10; k++) begin
         next_pulse(iv, dv);
         if (iv != 40) bad++;
      end
      chk(bad == 0, "R7 fraction zero gives constant length", bad, 0);

      // R6 mid-cycle load does not disturb current cycle
      repeat (10) @(negedge clk);
      do_load(50, 0, 9);
      chk(cerr == 1'b0, "R6 legal load keeps error clear", int'(cerr), 0);
      next_pulse(iv, dv);
      chk(iv == 40, "R6 cycle in progress unchanged", iv, 40);
      next_pulse(iv, dv);
      chk(iv == 50, "R6 new ratio from next cycle", iv, 50);

      // R3 / R4 / R5 rejections
      do_load(30, 0, 9);
      chk(cerr == 1'b1, "R3 integer below minimum flagged", int'(cerr), 1);
      do_load(45, 9, 9);
      chk(cerr == 1'b1, "R5 fraction not below modulus flagged", int'(cerr), 1);
      do_load(45, 0, 1);
      chk(cerr == 1'b1, "R4 modulus below minimum flagged", int'(cerr), 1);
      next_pulse(iv, dv);
      next_pulse(iv, dv);
      chk(iv == 50, "R3 R4 R5 rejected loads not applied", iv, 50);
      next_pulse(iv, dv);
      chk(iv == 50, "R3 period still unchanged", iv, 50);
      do_load(50, 0, 9);
      chk(cerr == 1'b0, "R6 legal load clears error", int'(cerr), 0);

      // R8 / R9 / R10 / R2 sweep of fractional settings
      foreach (cfgs[c]) begin
         next_pulse(iv, dv);
         repeat (5) @(negedge clk);
         do_load(cfgs[c][0], cfgs[c][1], cfgs[c][2]);
         next_pulse(iv, dv);
         next_pulse(iv, dv);
         chk(iv == cfgs[c][0], "R10 first cycle after apply", iv, cfgs[c][0]);
         next_pulse(iv, dv);
         n6  = 6 * cfgs[c][2];
         tot = 0;
         bad = 0;
         for (int k = 0; k < n6; k++) begin
            next_pulse(iv, dv);
            tot += iv;
            if (iv < cfgs[c][0] - 3 || iv > cfgs[c][0] + 4) bad++;
            if (iv != dv) begin
               bad++;
               $display("FAIL R2 interval vs length: actual %0d expected %0d", iv, dv);
            end
         end
         chk(tot == 6 * (cfgs[c][0] * cfgs[c][2] + cfgs[c][1]),
             "R8 exact mean ratio", tot,
             6 * (cfgs[c][0] * cfgs[c][2] + cfgs[c][1]));
         chk(bad == 0, "R9 R2 per-cycle length window", bad, 0);
      end

      // R11 reference divider ratios
      rdiv = 4'd5;
      repeat (20) @(negedge ref_clk);
      ref_interval(iv);
      chk(iv == 5, "R11 reference ratio 5", iv, 5);
      rdiv = 4'd15;
      repeat (20) @(negedge ref_clk);
      ref_interval(iv);
      chk(iv == 15, "R11 reference ratio 15", iv, 15);
      rdiv = 4'd1;
      repeat (3) @(negedge ref_clk);
      bad = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge ref_clk);
         if (!rpulse) bad++;
      end
      chk(bad == 0, "R11 reference ratio 1 continuous", bad, 0);

      // R12 illegal zero ratio
      rdiv = 4'd0;
      repeat (2) @(negedge ref_clk);
      chk(rerr == 1'b1, "R12 zero ratio flagged", int'(rerr), 1);
      bad = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge ref_clk);
         if (rpulse) bad++;
      end
      chk(bad == 0, "R12 zero ratio quiet", bad, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule